// File: doc/BRIEF.md
# Host Clock Output Selector

This block drives the single clock line that a bus transceiver hands to its host controller. It picks one of four outputs: the line held low, a coarse internally generated clock of about 4 MHz, the 16 MHz crystal clock divided by two, or the 16 MHz crystal clock itself. The choice depends on the current power state, a strap input, and how the device arrived in stand-by.

A power-state controller supplies a two-bit state code and an oscillator-fault flag in the control clock domain. On every state change the block records whether the new state is a stand-by that must fall back to the internal clock. That is the case when stand-by is entered from anywhere other than Normal, or from Normal because of an oscillator fault. The record is held until the next state change.

Each change of source is glitch-free. The control domain first withdraws the request of the running source. Each source stops its own enable on its own falling edge. Only after every acknowledge has returned low is the new source requested, and the new source enables itself on its own falling edge.

Top module: `hclk_out_sel`

## Requirements
- R1: The state code is 2'b00 Reset, 2'b01 Start-Up, 2'b10 Stand-By, 2'b11 Normal; in Reset and Start-Up the output is held low with no edges.
- R2: Stand-By entered from Start-Up (or from Reset) drives the internal clock (period about 248 ns in the bench).
- R3: In Normal the output is the crystal clock divided by two (125 ns) when strap_hi is 0, and the crystal clock itself (62.5 ns) when strap_hi is 1; a strap change while in Normal switches the output accordingly.
- R4: Stand-By entered from Normal with osc_fault low in the transition cycle keeps the crystal-derived clock chosen by strap_hi.
- R5: Stand-By entered from Normal with osc_fault high in the transition cycle switches the output to the internal clock.
- R6: osc_fault is used only in the cycle in which pwr_state changes; toggling it at any other time has no effect on the output.
- R7: No high or low phase of clk_host is shorter than half a period of the 16 MHz crystal clock, including the phases around a source change.
- R8: At most one source is enabled at any time, and a new source is requested only after every source acknowledge has returned low.
- R9: While rst_n is low, and after its release until a state selects a source, clk_host stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock of the power-state controller |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| pwr_state | input | 2 | Power-state code (R1 encoding) |
| osc_fault | input | 1 | Marks that a state change is caused by an oscillator fault |
| strap_hi | input | 1 | Strap level: 0 selects the divided crystal clock, 1 the full crystal clock |
| clk_x16 | input | 1 | 16 MHz crystal clock |
| clk_int | input | 1 | Coarse internal clock, about 4 MHz |
| clk_host | output | 1 | Clock line to the host controller |

## Verification
A source change takes one control cycle to withdraw the old request. The old source then needs up to its synchronizer depth plus half a cycle of its own clock to stop, and the acknowledge needs two control cycles to return. One more control cycle grants the new source, which then needs the same chain in its own domain. With the slowest source this totals well under 1.5 µs. The bench therefore waits 3 µs after each stimulus before it samples, and then measures the output period and edge count over a 2 µs window. A pulse-width monitor runs throughout the test, so the switching intervals that the window skips are still covered by the R7 check.

// File: rtl/hclk_pkg.sv
`timescale 1ns/1ps
package hclk_pkg;
  localparam int NUM_SRC = 3;
  // source mask bit positions
  localparam int B_INT = 0;
  localparam int B_X8  = 1;
  localparam int B_X16 = 2;

  typedef enum logic [1:0] {
    PS_RESET   = 2'b00,
    PS_STARTUP = 2'b01,
    PS_STANDBY = 2'b10,
    PS_NORMAL  = 2'b11
  } pstate_t;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_INT = 2'd1,
    SRC_X8  = 2'd2,
    SRC_X16 = 2'd3
  } src_t;

  // does entering next_st from prev_st require the internal clock
  function automatic logic needs_fallback(pstate_t prev_st, pstate_t next_st, logic fault);
    return (next_st == PS_STANDBY) && ((prev_st != PS_NORMAL) || fault);
  endfunction

  function automatic src_t pick_src(pstate_t st, logic fb, logic strap);
    src_t s;
    case (st)
      PS_STANDBY: s = fb ? SRC_INT : (strap ? SRC_X16 : SRC_X8);
      PS_NORMAL:  s = strap ? SRC_X16 : SRC_X8;
      default:    s = SRC_OFF;
    endcase
    return s;
  endfunction

  function automatic logic [NUM_SRC-1:0] src_mask(src_t s);
    logic [NUM_SRC-1:0] m;
    m = '0;
    case (s)
      SRC_INT: m[B_INT] = 1'b1;
      SRC_X8:  m[B_X8]  = 1'b1;
      SRC_X16: m[B_X16] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/hclk_cause_latch.sv
`timescale 1ns/1ps
module hclk_cause_latch
  import hclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pstate_t pwr_state,
  input  logic    osc_fault,
  output pstate_t prev_state,
  output logic    state_chg,
  output logic    fallback
);
  assign state_chg = (pwr_state != prev_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_state <= PS_RESET;
      fallback   <= 1'b0;
    end else if (state_chg) begin
      prev_state <= pwr_state;
      fallback   <= needs_fallback(prev_state, pwr_state, osc_fault);
    end
  end
endmodule

// File: rtl/hclk_div2.sv
`timescale 1ns/1ps
module hclk_div2 (
  input  logic clk_in,
  input  logic rst_n,
  output logic clk_out
);
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= ~clk_out;
  end
endmodule

// File: rtl/hclk_src_gate.sv
`timescale 1ns/1ps
module hclk_src_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic req,
  output logic en,
  output logic gclk
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], req};
  end

  // enable moves only on the falling edge, while src_clk is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= sync_q[SYNC_STAGES-1];
  end

  assign gclk = src_clk & en;
endmodule

// File: rtl/hclk_switch_ctrl.sv
`timescale 1ns/1ps
module hclk_switch_ctrl
  import hclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  src_t               want_src,
  input  logic [NUM_SRC-1:0] en_vec,
  output logic [NUM_SRC-1:0] req_vec,
  output logic [NUM_SRC-1:0] ack_vec,
  output src_t               cur_src
);
  typedef enum logic {PH_HOLD, PH_DRAIN} phase_t;
  phase_t phase;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_ack
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-2:0], en_vec[g]};
      end
      assign ack_vec[g] = s_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_HOLD;
      req_vec <= '0;
      cur_src <= SRC_OFF;
    end else begin
      case (phase)
        PH_HOLD: begin
          // leave only once the previous grant has fully settled
          if ((want_src != cur_src) && (ack_vec == req_vec)) begin
            req_vec <= '0;
            phase   <= PH_DRAIN;
          end
        end
        default: begin
          if (ack_vec == '0) begin
            req_vec <= src_mask(want_src);
            cur_src <= want_src;
            phase   <= PH_HOLD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hclk_out_sel.sv
`timescale 1ns/1ps
module hclk_out_sel
  import hclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_state,
  input  logic       osc_fault,
  input  logic       strap_hi,
  input  logic       clk_x16,
  input  logic       clk_int,
  output logic       clk_host
);
  pstate_t            st_in;
  pstate_t            prev_state;
  logic               state_chg;
  logic               int_fallback;
  src_t               want_src;
  src_t               cur_src;
  logic               clk_x8;
  logic [NUM_SRC-1:0] src_clks;
  logic [NUM_SRC-1:0] req_vec;
  logic [NUM_SRC-1:0] ack_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] gclk_vec;

  assign st_in = pstate_t'(pwr_state);

  hclk_cause_latch u_cause (
    .clk(clk), .rst_n(rst_n), .pwr_state(st_in), .osc_fault(osc_fault),
    .prev_state(prev_state), .state_chg(state_chg), .fallback(int_fallback)
  );

  assign want_src = pick_src(st_in, int_fallback, strap_hi);

  hclk_switch_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .want_src(want_src), .en_vec(en_vec),
    .req_vec(req_vec), .ack_vec(ack_vec), .cur_src(cur_src)
  );

  hclk_div2 u_div (.clk_in(clk_x16), .rst_n(rst_n), .clk_out(clk_x8));

  always_comb begin
    src_clks        = '0;
    src_clks[B_INT] = clk_int;
    src_clks[B_X8]  = clk_x8;
    src_clks[B_X16] = clk_x16;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      hclk_src_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .src_clk(src_clks[g]), .rst_n(rst_n), .req(req_vec[g]),
        .en(en_vec[g]), .gclk(gclk_vec[g])
      );
    end
  endgenerate

  assign clk_host = |gclk_vec;
endmodule

// File: rtl/hclk_out_sel_chk.sv
`timescale 1ns/1ps
module hclk_out_sel_chk
  import hclk_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         pwr_state,
  input logic               osc_fault,
  input pstate_t            prev_state,
  input logic               state_chg,
  input logic               int_fallback,
  input logic [NUM_SRC-1:0] req_vec,
  input logic [NUM_SRC-1:0] ack_vec
);
  // R8
  one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec));

  // R8
  grant_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_vec & ~$past(req_vec))) |-> ($past(ack_vec) == '0));

  // R1
  off_states_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 || pwr_state == 2'b01) |=> (req_vec == '0));

  // R6
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !state_chg |=> $stable(int_fallback));

  // R4
  keep_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_chg && pwr_state == 2'b10 && prev_state == PS_NORMAL && !osc_fault)
      |=> !int_fallback);

  // R5
  fault_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_chg && pwr_state == 2'b10 && osc_fault) |=> int_fallback);
endmodule

bind hclk_out_sel hclk_out_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .osc_fault(osc_fault),
  .prev_state(prev_state), .state_chg(state_chg), .int_fallback(int_fallback),
  .req_vec(req_vec), .ack_vec(ack_vec)
);

// File: tb/hclk_out_sel_test.sv
`timescale 1ns/1ps
module hclk_out_sel_test;
  logic       clk = 1'b0;
  logic       clk_x16 = 1'b0;
  logic       clk_int = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwr_state = 2'b00;
  logic       osc_fault = 1'b0;
  logic       strap_hi = 1'b0;
  logic       clk_host;

  int  n_tests = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  done = 0;

  // bench model
  logic [1:0] m_state = 2'b00;
  bit         m_fb = 0;

  // output monitors
  int  edge_cnt = 0;
  bit  have_rise = 0;
  real last_rise = 0.0;
  real last_period = 0.0;
  bit  have_edge = 0;
  real last_edge = 0.0;
  int  glitch_cnt = 0;
  real min_width = 1.0e9;

  always #5 clk = ~clk;
  always #31.25 clk_x16 = ~clk_x16;
  always #124 clk_int = ~clk_int;

  hclk_out_sel uut (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .osc_fault(osc_fault),
    .strap_hi(strap_hi), .clk_x16(clk_x16), .clk_int(clk_int), .clk_host(clk_host)
  );

  always @(posedge clk_host) begin
    if (have_rise) last_period = $realtime - last_rise;
    last_rise = $realtime;
    have_rise = 1;
    edge_cnt++;
  end

  always @(clk_host) begin
    if (have_edge) begin
      if (($realtime - last_edge) < min_width) min_width = $realtime - last_edge;
      if (($realtime - last_edge) < 30.0) glitch_cnt++;
    end
    last_edge = $realtime;
    have_edge = 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // expected output period from the requirements (0.0 = held low)
  function automatic real exp_period(logic [1:0] st, bit fb, logic strap);
    if (st == 2'b00 || st == 2'b01) return 0.0;        // R1
    if (st == 2'b10 && fb) return 248.0;               // R2 / R5
    return strap ? 62.5 : 125.0;                       // R3 / R4
  endfunction

  // apply a new state; fault level is the one seen in the transition cycle
  task automatic go_state(logic [1:0] st, logic fault, logic strap);
    @(negedge clk);
    if (st != m_state)
      m_fb = (st == 2'b10) && ((m_state != 2'b11) || fault);
    m_state = st;
    pwr_state = st;
    osc_fault = fault;
    strap_hi = strap;
    @(negedge clk);
    osc_fault = 1'b0;
  endtask

  task automatic measure(string req);
    real exp;
    exp = exp_period(m_state, m_fb, strap_hi);
    #3000;
    have_rise = 0;
    edge_cnt = 0;
    #2000;
    n_tests++;
    if (exp == 0.0) begin
      if (edge_cnt != 0 || clk_host !== 1'b0) begin
        n_fail++;
        $display("FAIL %s: edges=%0d level=%b expected edges=0 level=0",
                 req, edge_cnt, clk_host);
      end
    end else begin
      if (edge_cnt < 3 || last_period < exp - 1.0 || last_period > exp + 1.0) begin
        n_fail++;
        $display("FAIL %s: period=%0.2f edges=%0d expected period=%0.2f",
                 req, last_period, edge_cnt, exp);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    // R9: held in reset
    #400;
    n_tests++;
    if (clk_host !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: clk_host=%b expected 0 in reset", clk_host);
    end
    @(negedge clk);
    rst_n = 1'b1;
    measure("R9");
    go_state(2'b01, 1'b0, 1'b0); measure("R1");
    go_state(2'b10, 1'b0, 1'b1); measure("R2");
    go_state(2'b11, 1'b0, 1'b0); measure("R3");
    go_state(2'b11, 1'b0, 1'b1); measure("R3");
    go_state(2'b10, 1'b0, 1'b1); measure("R4");
    // R6: fault raised during stand-by must not change the source
    @(negedge clk);
    osc_fault = 1'b1;
    repeat (50) @(negedge clk);
    measure("R6");
    osc_fault = 1'b0;
    go_state(2'b11, 1'b0, 1'b0); measure("R3");
    go_state(2'b10, 1'b0, 1'b0); measure("R4");
    go_state(2'b11, 1'b0, 1'b1); measure("R3");
    go_state(2'b10, 1'b1, 1'b1); measure("R5");
    go_state(2'b00, 1'b0, 1'b1); measure("R1");
    go_state(2'b10, 1'b0, 1'b0); measure("R2");
    // random walk over the states
    for (int i = 0; i < 30; i++) begin
      logic [1:0] st;
      logic f, s;
      st = 2'($urandom_range(0, 3));
      f  = 1'($urandom_range(0, 1));
      s  = 1'($urandom_range(0, 1));
      go_state(st, f, s);
      if (st == 2'b10) begin
        // R6: stray fault while staying
        @(negedge clk);
        osc_fault = ~f;
        @(negedge clk);
        osc_fault = 1'b0;
      end
      measure(st == 2'b10 ? (m_fb ? "R5" : "R4") : (st[1] ? "R3" : "R1"));
    end
    // R7 / R8: no short pulse anywhere, including every switch
    n_tests++;
    if (glitch_cnt != 0) begin
      n_fail++;
      $display("FAIL R7/R8: %0d short phases, min width %0.2f expected >= 30.00",
               glitch_cnt, min_width);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule